// File: doc/BRIEF.md
# Data-Side Address Decoder

This block sits between a single load/store master and four slaves on the data side of a small processor. It takes one request at a time through a valid/ready channel, works out from the address which slave owns it, passes the request on to that slave, and sends the slave's answer back to the master. The four slaves are a large boot window, a 4 KB peripheral window, a 64 KB instruction RAM and a 64 KB data RAM. Everything else in the 32-bit address space is a hole.

A request to a hole does not go to any slave. The decoder accepts it on its own and answers one cycle later with the error flag set and zero read data. The decoder records which slave took a request at the moment it accepts it. The answer is then taken from that slave even if the master's address bus moves on, and any answer another slave produces in the meantime is ignored. Only one transaction is in flight at a time.

Slave indices are fixed: 0 is the boot window, 1 the peripheral window, 2 the instruction RAM and 3 the data RAM. Bit i of every per-slave vector and bits [32*i+31:32*i] of the packed read-data bus belong to slave i.

Top module: `dbus_router`

## Requirements
- R1: An address from 0x0000_0000 to 0x0FFF_FFFF raises only bit 0 of `s_req_valid`.
- R2: An address from 0x1000_0000 to 0x1000_0FFF raises only bit 1. 0x1000_1000 is unmapped. An error raised by this slave (in the bench, any access to offset 0xFFC) reaches `m_rsp_err`.
- R3: An address from 0x2000_0000 to 0x2000_FFFF raises only bit 2. 0x2001_0000 is unmapped.
- R4: An address from 0x8000_0000 to 0x8000_FFFF raises only bit 3. 0x8000_FFFC maps and 0x8001_0000 does not.
- R5: An unmapped request is accepted in the cycle it is presented and raises no slave valid. One cycle later it gets `m_rsp_valid`=1, `m_rsp_err`=1 and `m_rsp_rdata`=0.
- R6: Address, write flag, size, write data and byte strobes reach the slaves unchanged. A strobed write changes only the enabled bytes.
- R7: The response (data and error) comes from the slave latched at acceptance. Responses from any other slave, and later changes on `m_req_addr`, have no effect on it.
- R8: From the cycle after acceptance up to and including the response cycle, `m_req_ready` is 0 and no slave valid is raised. At most one slave valid is ever high. A response is never two cycles long.
- R9: While idle with a mapped request, `m_req_ready` follows the addressed slave's ready, so a slave stall holds off the master.
- R10: After reset the decoder is idle: no response valid and no slave valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Request accepted this cycle when high with valid |
| m_req_addr | input | 32 | Byte address |
| m_req_write | input | 1 | 1 for store, 0 for load |
| m_req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| m_req_wdata | input | 32 | Lane-aligned store data |
| m_req_wstrb | input | 4 | Byte enables for stores |
| m_rsp_valid | output | 1 | Response valid |
| m_rsp_rdata | output | 32 | Load data |
| m_rsp_err | output | 1 | Access fault |
| s_req_valid | output | 4 | Per-slave request valid |
| s_req_ready | input | 4 | Per-slave request ready |
| s_req_addr | output | 32 | Address to slaves |
| s_req_write | output | 1 | Write flag to slaves |
| s_req_size | output | 2 | Size to slaves |
| s_req_wdata | output | 32 | Write data to slaves |
| s_req_wstrb | output | 4 | Byte strobes to slaves |
| s_rsp_valid | input | 4 | Per-slave response valid |
| s_rsp_rdata | input | 128 | Packed per-slave read data |
| s_rsp_err | input | 4 | Per-slave error flag |

## Verification
The bench probes the first and last word of every region and the word just past it. A decoder with an off-by-one range, or with too few address bits compared, would send one of those requests to a slave instead of faulting, or fault a mapped one. During every response cycle, the slaves that were not selected drive junk data with error and valid set, and the master moves its address into a hole. A decoder that steered the response from the live address or from the wrong slave would return that junk. Stalled acceptance and a strobed write back-to-back with a read-back catch a ready that ignores the slave and a payload that is not passed through intact.

// File: rtl/dbus_router.sv
module dbus_router #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] BOOT_BASE = 32'h0000_0000,
  parameter int BOOT_BITS = 28,
  parameter logic [AW-1:0] MMIO_BASE = 32'h1000_0000,
  parameter int MMIO_BITS = 12,
  parameter logic [AW-1:0] IRAM_BASE = 32'h2000_0000,
  parameter int IRAM_BITS = 16,
  parameter logic [AW-1:0] DRAM_BASE = 32'h8000_0000,
  parameter int DRAM_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               m_req_valid,
  output logic               m_req_ready,
  input  logic [AW-1:0]      m_req_addr,
  input  logic               m_req_write,
  input  logic [1:0]         m_req_size,
  input  logic [DW-1:0]      m_req_wdata,
  input  logic [DW/8-1:0]    m_req_wstrb,
  output logic               m_rsp_valid,
  output logic [DW-1:0]      m_rsp_rdata,
  output logic               m_rsp_err,
  output logic [3:0]         s_req_valid,
  input  logic [3:0]         s_req_ready,
  output logic [AW-1:0]      s_req_addr,
  output logic               s_req_write,
  output logic [1:0]         s_req_size,
  output logic [DW-1:0]      s_req_wdata,
  output logic [DW/8-1:0]    s_req_wstrb,
  input  logic [3:0]         s_rsp_valid,
  input  logic [4*DW-1:0]    s_rsp_rdata,
  input  logic [3:0]         s_rsp_err
);
  localparam int NS = 4;
  localparam int SW = $clog2(NS);
  localparam logic [AW-1:0] BASE [NS] = '{BOOT_BASE, MMIO_BASE, IRAM_BASE, DRAM_BASE};
  localparam int SPAN [NS] = '{BOOT_BITS, MMIO_BITS, IRAM_BITS, DRAM_BITS};

  logic          busy_q, miss_q;
  logic [SW-1:0] sel_q, sel_d;
  logic [NS-1:0] hit;
  logic          any_hit, accept;

  for (genvar i = 0; i < NS; i++) begin : g_hit
    assign hit[i] = (m_req_addr >> SPAN[i]) == (BASE[i] >> SPAN[i]);
  end

  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NS; i++)
      if (hit[i]) sel_d = SW'(i);
  end

  assign any_hit     = |hit;
  assign m_req_ready = !busy_q && (any_hit ? s_req_ready[sel_d] : 1'b1);
  assign accept      = m_req_valid && m_req_ready;
  assign s_req_valid = (m_req_valid && !busy_q) ? hit : '0;

  assign s_req_addr  = m_req_addr;
  assign s_req_write = m_req_write;
  assign s_req_size  = m_req_size;
  assign s_req_wdata = m_req_wdata;
  assign s_req_wstrb = m_req_wstrb;

  assign m_rsp_valid = busy_q && (miss_q || s_rsp_valid[sel_q]);
  assign m_rsp_err   = m_rsp_valid && (miss_q || s_rsp_err[sel_q]);
  assign m_rsp_rdata = (m_rsp_valid && !miss_q) ? s_rsp_rdata[int'(sel_q)*DW +: DW] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      miss_q <= 1'b0;
      sel_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      miss_q <= !any_hit;
      sel_q  <= sel_d;
    end else if (m_rsp_valid) begin
      busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dbus_router_chk.sv
module dbus_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        m_req_valid,
  input logic        m_req_ready,
  input logic [31:0] m_req_addr,
  input logic        m_rsp_valid,
  input logic [31:0] m_rsp_rdata,
  input logic        m_rsp_err,
  input logic [3:0]  s_req_valid,
  input logic [3:0]  s_req_ready
);
  logic acc;
  assign acc = m_req_valid && m_req_ready;

  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_req_valid));

  a_r5_miss_answer: assert property (@(posedge clk) disable iff (!rst_n)
    acc && s_req_valid == 4'b0 |=> m_rsp_valid && m_rsp_err && m_rsp_rdata == 32'h0);

  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !m_req_ready && s_req_valid == 4'b0);

  a_r4_dram_route: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid && m_req_ready && m_req_addr[31:16] == 16'h8000 |-> s_req_valid == 4'b1000);

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req_valid & ~s_req_ready) != 4'b0 |-> !m_req_ready);

  a_r8_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    m_rsp_valid |=> !m_rsp_valid);
endmodule

bind dbus_router dbus_router_chk chk (.*);

// File: tb/tb_dbus_router.sv
module tb_dbus_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        m_req_valid = 1'b0, m_req_write = 1'b0;
  logic [31:0] m_req_addr = '0, m_req_wdata = '0;
  logic [1:0]  m_req_size = 2'd2;
  logic [3:0]  m_req_wstrb = '0;
  logic        m_req_ready, m_rsp_valid, m_rsp_err;
  logic [31:0] m_rsp_rdata;
  logic [3:0]  s_req_valid, s_req_ready, s_rsp_valid, s_rsp_err;
  logic [31:0] s_req_addr, s_req_wdata;
  logic        s_req_write;
  logic [1:0]  s_req_size;
  logic [3:0]  s_req_wstrb;
  logic [127:0] s_rsp_rdata;

  logic [3:0]  s_rdy = 4'hF, junk = 4'h0;
  logic [3:0]  rv, re;
  logic [31:0] rd [4];
  logic [31:0] mem [4][16];
  logic [31:0] exp_mem [4][16];

  int checks = 0, fails = 0;
  bit done = 1'b0;

  dbus_router dut (.*);

  assign s_req_ready = s_rdy;
  for (genvar i = 0; i < 4; i++) begin : g_slv
    assign s_rsp_valid[i] = rv[i] | junk[i];
    assign s_rsp_err[i]   = re[i] | junk[i];
    assign s_rsp_rdata[32*i +: 32] = junk[i] ? 32'hDEAD_BEEF : rd[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rv[i] <= 1'b0; re[i] <= 1'b0; rd[i] <= '0;
      end else if (s_req_valid[i] && s_req_ready[i]) begin
        rv[i] <= 1'b1;
        re[i] <= (i == 1) && (s_req_addr[11:0] == 12'hFFC);
        rd[i] <= s_req_write ? 32'h0 : mem[i][s_req_addr[5:2]];
        if (s_req_write)
          for (int b = 0; b < 4; b++)
            if (s_req_wstrb[b]) mem[i][s_req_addr[5:2]][8*b +: 8] <= s_req_wdata[8*b +: 8];
      end else begin
        rv[i] <= 1'b0; re[i] <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int region(input logic [31:0] a);
    if (a < 32'h1000_0000) return 0;
    if (a >= 32'h1000_0000 && a <= 32'h1000_0FFF) return 1;
    if (a >= 32'h2000_0000 && a < 32'h2001_0000) return 2;
    if (a >= 32'h8000_0000 && a < 32'h8001_0000) return 3;
    return -1;
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) chk($countones(s_req_valid) <= 1, "R8 one target", s_req_valid, 4'h1);
  end

  task automatic txn(input logic [31:0] a, input logic w, input logic [31:0] wd,
                     input logic [3:0] st, input int stall, input logic [3:0] jk);
    int s = region(a);
    string tag = (s == 0) ? "R1" : (s == 1) ? "R2" : (s == 2) ? "R3" : (s == 3) ? "R4" : "R5";
    logic [3:0]  emask = (s < 0) ? 4'h0 : (4'h1 << s);
    logic [31:0] erd = 32'h0;
    logic        eerr = (s < 0) || (s == 1 && a[11:0] == 12'hFFC);
    @(negedge clk);
    m_req_valid = 1'b1; m_req_addr = a; m_req_write = w; m_req_wdata = wd;
    m_req_wstrb = st; m_req_size = 2'd2;
    if (s >= 0 && stall > 0) s_rdy[s] = 1'b0;
    for (int k = 0; k < stall; k++) begin
      #1;
      chk(m_req_ready == 1'b0, "R9 stall", m_req_ready, 1'b0);
      @(negedge clk);
    end
    s_rdy = 4'hF;
    #1;
    chk(m_req_ready == 1'b1, {tag, " accept"}, m_req_ready, 1'b1);
    chk(s_req_valid == emask, {tag, " route"}, s_req_valid, emask);
    if (s >= 0)
      chk(s_req_addr == a && s_req_write == w && s_req_wdata == wd && s_req_wstrb == st && s_req_size == 2'd2,
          "R6 payload", {s_req_addr, s_req_wdata, s_req_wstrb}, {a, wd, st});
    if (s >= 0 && !w) erd = exp_mem[s][a[5:2]];
    if (s >= 0 && w)
      for (int b = 0; b < 4; b++) if (st[b]) exp_mem[s][a[5:2]][8*b +: 8] = wd[8*b +: 8];
    @(negedge clk);
    m_req_valid = 1'b0; m_req_addr = 32'hFFFF_FFF0;
    if (s >= 0) jk[s] = 1'b0;
    junk = jk;
    #1;
    chk(m_rsp_valid == 1'b1, {tag, " R7 rsp valid"}, m_rsp_valid, 1'b1);
    chk(m_rsp_rdata == erd, {tag, " R7 rsp data"}, m_rsp_rdata, erd);
    chk(m_rsp_err == eerr, {tag, " R7 rsp err"}, m_rsp_err, eerr);
    chk(m_req_ready == 1'b0 && s_req_valid == 4'h0, "R8 busy", {m_req_ready, s_req_valid}, 5'h0);
    @(negedge clk);
    junk = 4'h0;
    #1;
    chk(m_rsp_valid == 1'b0, "R8 rsp once", m_rsp_valid, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 16; j++) begin mem[i][j] = '0; exp_mem[i][j] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_rsp_valid == 1'b0 && s_req_valid == 4'h0, "R10 reset idle", {m_rsp_valid, s_req_valid}, 5'h0);
    txn(32'h0000_0010, 1, 32'h1111_2222, 4'hF, 0, 4'h0);
    txn(32'h0000_0010, 0, 0, 0, 0, 4'hF);
    txn(32'h0FFF_FFFC, 1, 32'hA5A5_0F0F, 4'hF, 0, 4'h0);
    txn(32'h0FFF_FFFC, 0, 0, 0, 1, 4'hF);
    txn(32'h1000_0000, 1, 32'h0000_00CC, 4'h1, 0, 4'h0);
    txn(32'h1000_0000, 0, 0, 0, 0, 4'hF);
    txn(32'h1000_0FFC, 0, 0, 0, 0, 4'hF);
    txn(32'h1000_1000, 0, 0, 0, 0, 4'hF);
    txn(32'h2000_0004, 1, 32'h1234_5678, 4'hF, 0, 4'h0);
    txn(32'h2000_0004, 1, 32'hFFFF_FFFF, 4'b0101, 2, 4'h0);
    txn(32'h2000_0004, 0, 0, 0, 0, 4'hF);
    txn(32'h2000_FFFC, 1, 32'h0BAD_F00D, 4'hF, 0, 4'h0);
    txn(32'h2000_FFFC, 0, 0, 0, 0, 4'hF);
    txn(32'h2001_0000, 1, 32'h5555_5555, 4'hF, 0, 4'hF);
    txn(32'h8000_0008, 1, 32'hCAFE_0001, 4'hF, 3, 4'h0);
    txn(32'h8000_0008, 0, 0, 0, 3, 4'hF);
    txn(32'h8000_FFFC, 1, 32'h7777_8888, 4'b1000, 0, 4'h0);
    txn(32'h8000_FFFC, 0, 0, 0, 0, 4'hF);
    txn(32'h8001_0000, 0, 0, 0, 0, 4'hF);
    txn(32'h7FFF_FFFC, 0, 0, 0, 0, 4'hF);
    txn(32'hFFFF_FFFC, 1, 32'h1, 4'hF, 0, 4'hF);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule